// File: doc/BRIEF.md
# Direct/Indirect Receive Channel Scheduler

This block sits on the receive side of a hardware TCP engine. It handles one payload notification at a time. Each notification carries a session index and a payload length X. The block first reads how many bytes of that session are still waiting in the off-chip buffer (X', kept in an internal length table). It then asks the application, through a request/acknowledge handshake, how many bytes it can take right now (the credit Y).

When the application can take the whole payload and nothing older is pending for that session, the payload goes out on the fast path. The block posts the length to a direct-report queue, and the on-chip payload FIFO feeds the application. In every other case the payload counts as buffered off-chip. X is added to the pending amount, the application is queried again, and a single read slice of min(X', Y) bytes is requested from the external memory. The slice starts at the session's read pointer. A zero credit starts a new query round. Each slice is reported to a pointer update unit, and the decreased pending amount is written back to the length table. Whatever is still pending is served on later notifications of the same session.

The pointer table is written from outside, by connection setup and by the pointer update unit, and is read by this block. After reset the block clears its length table before it accepts any notification.

Top module: `rx_chan_sched`

## Requirements
- R1: `ntf_pop` is high only in a cycle where `ntf_valid` and `pay_avail` are both high and the block is idle. Two cycles after a pop, `app_req` is high with `app_sess` equal to the popped session.
- R2: While `app_ack` is low, `app_req` stays high and `app_sess` does not change. The credit `app_credit` is taken in the cycle where `app_req` and `app_ack` are both high.
- R3: Take the first query after a pop. If X <= Y and the session's pending length is 0, then in the cycle after the acknowledge `dir_wr` is high, with `dir_sess` set to the session and `dir_len` set to X.
- R4: Otherwise no direct report is made. X is added to the session's pending length and a second query round follows. `dir_wr` and `rd_req` are never high in the same cycle.
- R5: An acknowledge with credit 0 in a second-round query produces no read. In the cycle after it `app_req` is low, and in the cycle after that `app_req` is high again.
- R6: An acknowledge with nonzero credit in a second-round query is followed, two cycles later, by a single cycle with `rd_req` high. In that cycle `rd_len` = min(pending, Y) and `rd_addr` is the session's current pointer-table entry.
- R7: After a read, the pending length minus `rd_len` is stored for the session and is used by that session's next notification.
- R8: `upd_valid` is high exactly in the cycles where `rd_req` is high, and `upd_sess`/`upd_len` then equal `rd_sess`/`rd_len`.
- R9: During reset all outputs are low. After reset is released the length table is cleared to 0. The first pop happens in the cycle after the 2^SESS_W-th rising clock edge that sees reset released.
- R10: Once every session has drained, the sum of direct lengths and read lengths for each session equals the sum of the payload lengths notified for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ntf_valid | input | 1 | A payload notification is waiting (state queue not empty) |
| ntf_sess | input | SESS_W | Session index of the waiting notification |
| ntf_len | input | LEN_W | Payload length X of the waiting notification |
| pay_avail | input | 1 | On-chip payload FIFO holds data |
| ntf_pop | output | 1 | Notification consumed at this clock edge |
| app_req | output | 1 | Credit query to the application |
| app_sess | output | SESS_W | Session being queried |
| app_ack | input | 1 | Application answers the query |
| app_credit | input | LEN_W | Bytes the application can accept (Y) |
| dir_wr | output | 1 | Push into the direct-report queue |
| dir_sess | output | SESS_W | Session of the direct report |
| dir_len | output | LEN_W | Direct length |
| rd_req | output | 1 | Off-chip read slice request |
| rd_sess | output | SESS_W | Session of the slice |
| rd_addr | output | ADDR_W | Start address of the slice |
| rd_len | output | LEN_W | Slice length |
| upd_valid | output | 1 | Record to the pointer update unit |
| upd_sess | output | SESS_W | Session of the record |
| upd_len | output | LEN_W | Slice length of the record |
| ptr_we | input | 1 | Pointer table write strobe |
| ptr_wsess | input | SESS_W | Pointer table write index |
| ptr_wdata | input | ADDR_W | Pointer table write value |

## Verification
A wrong pending length in the length table shows up at the ports on the next notification of that session. It appears one cycle after that notification's first acknowledge, as a direct report that should have been a second query round or the other way round. Or it appears two cycles after the second acknowledge, as a wrong `rd_len`. A stale or misread pointer shows up as a wrong `rd_addr` in the very cycle of the read. A lost or doubled slice only shows up when the direct and slice lengths of each session are added up against the notified payload once the session has drained. So the reference model tracks per-session pending lengths and pointers, and predicts every report and read to the exact cycle.

// File: rtl/rxs_pkg.sv
package rxs_pkg;

    typedef enum logic [3:0] {
        ST_INIT  = 4'd0,
        ST_IDLE  = 4'd1,
        ST_LWAIT = 4'd2,
        ST_DQRY  = 4'd3,
        ST_DPOST = 4'd4,
        ST_IQRY  = 4'd5,
        ST_IGAP  = 4'd6,
        ST_PRD   = 4'd7,
        ST_ISS   = 4'd8
    } st_e;

endpackage

// File: rtl/rxs_ram.sv
module rxs_ram #(
    parameter int AW = 10,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        rdata <= mem[raddr];
    end

endmodule

// File: rtl/rxs_fsm.sv
module rxs_fsm
    import rxs_pkg::*;
#(
    parameter int SESS_W = 10,
    parameter int LEN_W  = 16,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ntf_valid,
    input  logic [SESS_W-1:0] ntf_sess,
    input  logic [LEN_W-1:0]  ntf_len,
    input  logic              pay_avail,
    output logic              ntf_pop,
    output logic              app_req,
    output logic [SESS_W-1:0] app_sess,
    input  logic              app_ack,
    input  logic [LEN_W-1:0]  app_credit,
    output logic              dir_wr,
    output logic [SESS_W-1:0] dir_sess,
    output logic [LEN_W-1:0]  dir_len,
    output logic              rd_req,
    output logic [SESS_W-1:0] rd_sess,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [LEN_W-1:0]  rd_len,
    output logic              upd_valid,
    output logic [SESS_W-1:0] upd_sess,
    output logic [LEN_W-1:0]  upd_len,
    output logic              len_we,
    output logic [SESS_W-1:0] len_waddr,
    output logic [LEN_W-1:0]  len_wdata,
    output logic [SESS_W-1:0] len_raddr,
    input  logic [LEN_W-1:0]  len_rdata,
    output logic [SESS_W-1:0] ptr_raddr,
    input  logic [ADDR_W-1:0] ptr_rdata
);
    localparam logic [SESS_W-1:0] LAST_IDX = '1;

    typedef struct packed {
        st_e               st;
        logic [SESS_W-1:0] cnt;
        logic [SESS_W-1:0] sess;
        logic [LEN_W-1:0]  x;
        logic [LEN_W-1:0]  xr;
        logic [LEN_W-1:0]  slice;
    } regs_t;

    regs_t r_q, r_d;

    always_comb begin
        r_d       = r_q;
        ntf_pop   = 1'b0;
        app_req   = 1'b0;
        dir_wr    = 1'b0;
        rd_req    = 1'b0;
        upd_valid = 1'b0;
        len_we    = 1'b0;
        len_waddr = r_q.sess;
        len_wdata = r_q.xr - r_q.slice;
        len_raddr = ntf_sess;
        ptr_raddr = r_q.sess;

        unique case (r_q.st)
            ST_INIT: begin
                len_we    = 1'b1;
                len_waddr = r_q.cnt;
                len_wdata = '0;
                r_d.cnt   = r_q.cnt + 1'b1;
                if (r_q.cnt == LAST_IDX) begin
                    r_d.st = ST_IDLE;
                end
            end
            ST_IDLE: begin
                if (ntf_valid && pay_avail) begin
                    ntf_pop  = 1'b1;
                    r_d.sess = ntf_sess;
                    r_d.x    = ntf_len;
                    r_d.st   = ST_LWAIT;
                end
            end
            ST_LWAIT: begin
                r_d.xr = len_rdata;
                r_d.st = ST_DQRY;
            end
            ST_DQRY: begin
                app_req = 1'b1;
                if (app_ack) begin
                    if ((r_q.x <= app_credit) && (r_q.xr == '0)) begin
                        r_d.st = ST_DPOST;
                    end else begin
                        r_d.xr = r_q.xr + r_q.x;
                        r_d.st = ST_IQRY;
                    end
                end
            end
            ST_DPOST: begin
                dir_wr = 1'b1;
                r_d.st = ST_IDLE;
            end
            ST_IQRY: begin
                app_req = 1'b1;
                if (app_ack) begin
                    if (app_credit == '0) begin
                        r_d.st = ST_IGAP;
                    end else begin
                        r_d.slice = (r_q.xr < app_credit) ? r_q.xr : app_credit;
                        r_d.st    = ST_PRD;
                    end
                end
            end
            ST_IGAP: begin
                r_d.st = ST_IQRY;
            end
            ST_PRD: begin
                r_d.st = ST_ISS;
            end
            ST_ISS: begin
                rd_req    = 1'b1;
                upd_valid = 1'b1;
                len_we    = 1'b1;
                r_d.xr    = r_q.xr - r_q.slice;
                r_d.st    = ST_IDLE;
            end
            default: begin
                r_d.st = ST_IDLE;
            end
        endcase
    end

    assign app_sess = r_q.sess;
    assign dir_sess = r_q.sess;
    assign dir_len  = r_q.x;
    assign rd_sess  = r_q.sess;
    assign rd_addr  = ptr_rdata;
    assign rd_len   = r_q.slice;
    assign upd_sess = r_q.sess;
    assign upd_len  = r_q.slice;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

endmodule

// File: rtl/rx_chan_sched.sv
module rx_chan_sched #(
    parameter int SESS_W = 10,
    parameter int LEN_W  = 16,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ntf_valid,
    input  logic [SESS_W-1:0] ntf_sess,
    input  logic [LEN_W-1:0]  ntf_len,
    input  logic              pay_avail,
    output logic              ntf_pop,
    output logic              app_req,
    output logic [SESS_W-1:0] app_sess,
    input  logic              app_ack,
    input  logic [LEN_W-1:0]  app_credit,
    output logic              dir_wr,
    output logic [SESS_W-1:0] dir_sess,
    output logic [LEN_W-1:0]  dir_len,
    output logic              rd_req,
    output logic [SESS_W-1:0] rd_sess,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [LEN_W-1:0]  rd_len,
    output logic              upd_valid,
    output logic [SESS_W-1:0] upd_sess,
    output logic [LEN_W-1:0]  upd_len,
    input  logic              ptr_we,
    input  logic [SESS_W-1:0] ptr_wsess,
    input  logic [ADDR_W-1:0] ptr_wdata
);
    logic              len_we;
    logic [SESS_W-1:0] len_waddr;
    logic [LEN_W-1:0]  len_wdata;
    logic [SESS_W-1:0] len_raddr;
    logic [LEN_W-1:0]  len_rdata;
    logic [SESS_W-1:0] ptr_raddr;
    logic [ADDR_W-1:0] ptr_rdata;

    rxs_ram #(.AW(SESS_W), .DW(LEN_W)) u_len_tab (
        .clk   (clk),
        .we    (len_we),
        .waddr (len_waddr),
        .wdata (len_wdata),
        .raddr (len_raddr),
        .rdata (len_rdata)
    );

    rxs_ram #(.AW(SESS_W), .DW(ADDR_W)) u_ptr_tab (
        .clk   (clk),
        .we    (ptr_we),
        .waddr (ptr_wsess),
        .wdata (ptr_wdata),
        .raddr (ptr_raddr),
        .rdata (ptr_rdata)
    );

    rxs_fsm #(.SESS_W(SESS_W), .LEN_W(LEN_W), .ADDR_W(ADDR_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .ntf_valid  (ntf_valid),
        .ntf_sess   (ntf_sess),
        .ntf_len    (ntf_len),
        .pay_avail  (pay_avail),
        .ntf_pop    (ntf_pop),
        .app_req    (app_req),
        .app_sess   (app_sess),
        .app_ack    (app_ack),
        .app_credit (app_credit),
        .dir_wr     (dir_wr),
        .dir_sess   (dir_sess),
        .dir_len    (dir_len),
        .rd_req     (rd_req),
        .rd_sess    (rd_sess),
        .rd_addr    (rd_addr),
        .rd_len     (rd_len),
        .upd_valid  (upd_valid),
        .upd_sess   (upd_sess),
        .upd_len    (upd_len),
        .len_we     (len_we),
        .len_waddr  (len_waddr),
        .len_wdata  (len_wdata),
        .len_raddr  (len_raddr),
        .len_rdata  (len_rdata),
        .ptr_raddr  (ptr_raddr),
        .ptr_rdata  (ptr_rdata)
    );

endmodule

// File: rtl/rx_chan_sched_chk.sv
module rx_chan_sched_chk #(
    parameter int SESS_W = 10,
    parameter int LEN_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ntf_valid,
    input logic              pay_avail,
    input logic              ntf_pop,
    input logic              app_req,
    input logic [SESS_W-1:0] app_sess,
    input logic              app_ack,
    input logic [LEN_W-1:0]  app_credit,
    input logic              dir_wr,
    input logic [LEN_W-1:0]  dir_len,
    input logic              rd_req,
    input logic [SESS_W-1:0] rd_sess,
    input logic [LEN_W-1:0]  rd_len,
    input logic              upd_valid,
    input logic [SESS_W-1:0] upd_sess,
    input logic [LEN_W-1:0]  upd_len
);
    // R1: a pop needs both queues non-empty and leads to a query two cycles on
    a_r1_pop_gate: assert property (@(posedge clk) disable iff (!rst_n)
        ntf_pop |-> (ntf_valid && pay_avail));
    a_r1_pop_then_query: assert property (@(posedge clk) disable iff (!rst_n)
        ntf_pop |=> ##1 app_req);

    // R2: request and session are held until acknowledged
    a_r2_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (app_req && !app_ack) |=> (app_req && $stable(app_sess)));

    // R3: a direct report follows an acknowledge whose credit covers it
    a_r3_dir_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        dir_wr |-> $past(app_req && app_ack && (app_credit >= dir_len)));

    // R4: the two paths never fire together
    a_r4_excl_paths: assert property (@(posedge clk) disable iff (!rst_n)
        !(dir_wr && rd_req));

    // R5: a zero credit never produces a read two cycles later
    a_r5_zero_no_read: assert property (@(posedge clk) disable iff (!rst_n)
        (app_req && app_ack && (app_credit == '0)) |=> ##1 !rd_req);

    // R6: a read follows a nonzero acknowledge by two cycles and is never empty
    a_r6_read_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> ($past(app_req && app_ack && (app_credit != '0), 2) && (rd_len != '0)));

    // R8: pointer update record accompanies each read
    a_r8_upd_match: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req || upd_valid) |-> (rd_req && upd_valid && (upd_sess == rd_sess) && (upd_len == rd_len)));

endmodule

bind rx_chan_sched rx_chan_sched_chk #(.SESS_W(SESS_W), .LEN_W(LEN_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ntf_valid  (ntf_valid),
    .pay_avail  (pay_avail),
    .ntf_pop    (ntf_pop),
    .app_req    (app_req),
    .app_sess   (app_sess),
    .app_ack    (app_ack),
    .app_credit (app_credit),
    .dir_wr     (dir_wr),
    .dir_len    (dir_len),
    .rd_req     (rd_req),
    .rd_sess    (rd_sess),
    .rd_len     (rd_len),
    .upd_valid  (upd_valid),
    .upd_sess   (upd_sess),
    .upd_len    (upd_len)
);

// File: tb/test_rx_chan_sched.sv
module test_rx_chan_sched;
    localparam int SESS_W = 10;
    localparam int LEN_W  = 16;
    localparam int ADDR_W = 32;
    localparam int DEPTH  = 1 << SESS_W;
    localparam int NN     = 8;
    localparam int NB     = 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ntf_valid = 1'b0;
    logic [SESS_W-1:0] ntf_sess = '0;
    logic [LEN_W-1:0]  ntf_len = '0;
    logic              pay_avail = 1'b0;
    logic              ntf_pop;
    logic              app_req;
    logic [SESS_W-1:0] app_sess;
    logic              app_ack = 1'b0;
    logic [LEN_W-1:0]  app_credit = '0;
    logic              dir_wr;
    logic [SESS_W-1:0] dir_sess;
    logic [LEN_W-1:0]  dir_len;
    logic              rd_req;
    logic [SESS_W-1:0] rd_sess;
    logic [ADDR_W-1:0] rd_addr;
    logic [LEN_W-1:0]  rd_len;
    logic              upd_valid;
    logic [SESS_W-1:0] upd_sess;
    logic [LEN_W-1:0]  upd_len;
    logic              ptr_we = 1'b0;
    logic [SESS_W-1:0] ptr_wsess = '0;
    logic [ADDR_W-1:0] ptr_wdata = '0;

    always #10 clk = ~clk;

    rx_chan_sched #(.SESS_W(SESS_W), .LEN_W(LEN_W), .ADDR_W(ADDR_W)) i_rx_chan_sched (
        .clk(clk), .rst_n(rst_n), .ntf_valid(ntf_valid), .ntf_sess(ntf_sess),
        .ntf_len(ntf_len), .pay_avail(pay_avail), .ntf_pop(ntf_pop),
        .app_req(app_req), .app_sess(app_sess), .app_ack(app_ack),
        .app_credit(app_credit), .dir_wr(dir_wr), .dir_sess(dir_sess),
        .dir_len(dir_len), .rd_req(rd_req), .rd_sess(rd_sess), .rd_addr(rd_addr),
        .rd_len(rd_len), .upd_valid(upd_valid), .upd_sess(upd_sess),
        .upd_len(upd_len), .ptr_we(ptr_we), .ptr_wsess(ptr_wsess),
        .ptr_wdata(ptr_wdata)
    );

    int nchk = 0;
    int nbad = 0;

    // scenario and reference state
    int n_sess [NN];
    int n_len  [NN];
    int n_hold [NN];
    int b_sess [NB];
    int cred [$];
    int rem   [DEPTH];
    int ptrm  [DEPTH];
    int pu    [DEPTH];
    int got   [DEPTH];
    int total [DEPTH];
    int ed_due [$];
    int ed_sess[$];
    int ed_len [$];
    int er_due [$];
    int er_sess[$];
    int er_len [$];
    int er_addr[$];

    int cyc, ni, bi, hold, phase, cur_s, cur_x, wcnt, nack, rq_due, quiet;
    bit pend, ack_on, first_seen, done;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic present(input int i);
        ntf_valid = 1'b1;
        ntf_sess  = SESS_W'(n_sess[i]);
        ntf_len   = LEN_W'(n_len[i]);
        hold      = n_hold[i];
        pay_avail = (hold == 0);
    endtask

    task automatic model_ack(input int y);
        int sl;
        if (phase == 1) begin
            if (cur_x <= y && rem[cur_s] == 0) begin
                ed_due.push_back(cyc + 1);
                ed_sess.push_back(cur_s);
                ed_len.push_back(cur_x);
                ptrm[cur_s] += cur_x;
                phase = 0;
            end else begin
                rem[cur_s] += cur_x;
                phase = 2;
            end
        end else if (phase == 2) begin
            if (y == 0) begin
                rq_due = cyc + 2;
            end else begin
                sl = (rem[cur_s] < y) ? rem[cur_s] : y;
                er_due.push_back(cyc + 2);
                er_sess.push_back(cur_s);
                er_len.push_back(sl);
                er_addr.push_back(ptrm[cur_s]);
                ptrm[cur_s] += sl;
                rem[cur_s]  -= sl;
                phase = 0;
            end
        end
    endtask

    initial begin
        n_sess = '{5, 5, 5, 0, 1023, 0, 1023, 9};
        n_len  = '{100, 300, 10, 64, 50, 8, 0, 40};
        n_hold = '{0, 0, 0, 6, 0, 0, 0, 0};
        b_sess = '{5, 0, 1023, 9, 3};
        cred = {200, 200, 0, 120, 500, 500, 64, 49, 30, 8, 100, 100, 0, 40};

        repeat (3) @(negedge clk);
        // R9 outputs quiet in reset
        chk(!ntf_pop && !app_req && !dir_wr && !rd_req && !upd_valid,
            "R9 outputs low in reset", {ntf_pop, app_req, dir_wr, rd_req, upd_valid}, 0);

        cyc = 0; ni = 0; bi = 0; phase = 0; wcnt = 0; nack = 0; rq_due = -10; quiet = 0;
        pend = 0; ack_on = 0; first_seen = 0; done = 0;
        present(0);
        rst_n = 1'b1;

        while (!done) begin
            bit obs_pop, obs_req;
            @(negedge clk);
            cyc++;
            obs_pop = ntf_pop;
            obs_req = app_req;
            ptr_we  = 1'b0;

            if (obs_pop && !first_seen) begin
                first_seen = 1;
                chk(cyc == DEPTH, "R9 first pop after table clear", cyc, DEPTH);
            end
            if (!pay_avail) chk(!obs_pop, "R1 pop while payload FIFO empty", obs_pop, 0);
            if (cyc == rq_due - 1) chk(!obs_req, "R5 request low after zero credit", obs_req, 0);
            if (cyc == rq_due) chk(obs_req, "R5 request raised again", obs_req, 1);

            // direct reports
            if (dir_wr) begin
                if (ed_due.size() == 0 || ed_due[0] != cyc) begin
                    chk(0, "R4 unexpected direct report", dir_len, -1);
                end else begin
                    chk(dir_sess == SESS_W'(ed_sess[0]), "R3 direct session", dir_sess, ed_sess[0]);
                    chk(dir_len == LEN_W'(ed_len[0]), "R3 direct length", dir_len, ed_len[0]);
                    void'(ed_due.pop_front()); void'(ed_sess.pop_front()); void'(ed_len.pop_front());
                end
                got[dir_sess] += int'(dir_len);
                pu[dir_sess]  += int'(dir_len);
                ptr_we = 1'b1; ptr_wsess = dir_sess; ptr_wdata = ADDR_W'(pu[dir_sess]);
            end else if (ed_due.size() != 0 && ed_due[0] == cyc) begin
                chk(0, "R3 missing direct report", 0, ed_len[0]);
                void'(ed_due.pop_front()); void'(ed_sess.pop_front()); void'(ed_len.pop_front());
            end

            // read slices
            if (rd_req) begin
                chk(upd_valid && upd_sess == rd_sess && upd_len == rd_len,
                    "R8 update record mismatch", upd_len, rd_len);
                if (er_due.size() == 0 || er_due[0] != cyc) begin
                    chk(0, "R5 unexpected read", rd_len, -1);
                end else begin
                    chk(rd_sess == SESS_W'(er_sess[0]), "R6 read session", rd_sess, er_sess[0]);
                    chk(rd_len == LEN_W'(er_len[0]), "R6 R7 slice length", rd_len, er_len[0]);
                    chk(rd_addr == ADDR_W'(er_addr[0]), "R6 read address", longint'(rd_addr), er_addr[0]);
                    void'(er_due.pop_front()); void'(er_sess.pop_front());
                    void'(er_len.pop_front()); void'(er_addr.pop_front());
                end
                got[rd_sess] += int'(rd_len);
                pu[rd_sess]  += int'(rd_len);
                ptr_we = 1'b1; ptr_wsess = rd_sess; ptr_wdata = ADDR_W'(pu[rd_sess]);
            end else begin
                if (upd_valid) chk(0, "R8 update without read", upd_len, 0);
                if (er_due.size() != 0 && er_due[0] == cyc) begin
                    chk(0, "R6 missing read", 0, er_len[0]);
                    void'(er_due.pop_front()); void'(er_sess.pop_front());
                    void'(er_len.pop_front()); void'(er_addr.pop_front());
                end
            end

            // pointer table setup (connection building) during the clear sweep
            if (!ptr_we && bi < NB) begin
                int s;
                s = b_sess[bi];
                pu[s] = s * 4096 + 16;
                ptrm[s] = pu[s];
                ptr_we = 1'b1; ptr_wsess = SESS_W'(s); ptr_wdata = ADDR_W'(pu[s]);
                bi++;
            end

            // notification source
            if (pend) begin
                pend = 0;
                ni++;
                if (ni < NN) present(ni);
                else begin ntf_valid = 1'b0; pay_avail = 1'b0; end
            end else if (obs_pop) begin
                cur_s = n_sess[ni];
                cur_x = n_len[ni];
                total[cur_s] += cur_x;
                phase = 1;
                pend = 1;
            end else if (ntf_valid && hold > 0) begin
                hold--;
                if (hold == 0) pay_avail = 1'b1;
            end

            // application credit responder
            if (ack_on) begin
                app_ack = 1'b0;
                ack_on  = 0;
            end else if (obs_req) begin
                chk(app_sess == SESS_W'(cur_s), "R2 queried session", app_sess, cur_s);
                if (wcnt < nack % 3) begin
                    wcnt++;
                end else begin
                    int y;
                    y = (cred.size() != 0) ? cred.pop_front() : 1000;
                    wcnt = 0;
                    app_ack = 1'b1;
                    app_credit = LEN_W'(y);
                    ack_on = 1;
                    nack++;
                    model_ack(y);
                end
            end

            if (ni >= NN && !pend && phase == 0 && ed_due.size() == 0 && er_due.size() == 0)
                quiet++;
            else
                quiet = 0;
            if (quiet >= 8) done = 1;
            if (cyc > 20000) begin
                chk(0, "watchdog expired", cyc, 20000);
                done = 1;
            end
        end

        // R10 per-session conservation
        for (int k = 0; k < 4; k++) begin
            int s;
            s = b_sess[k];
            chk(got[s] == total[s], "R10 delivered equals notified", got[s], total[s]);
            chk(rem[s] == 0, "R10 session drained", rem[s], 0);
        end

        $display("test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end

endmodule